// File: doc/BRIEF.md
# Compare-Match Interval Timer

This block is a 32-bit up-counter with a programmable compare value, reached through a small memory-mapped register bus. While the run bit is set, the counter advances by one on every clock. When the count equals the compare value, the block sets a sticky match flag. If the match interrupt is enabled, the flag drives the interrupt line.

Two run modes are available. In periodic mode, a match returns the counter to zero on the next clock, and counting goes on. The period is therefore the compare value plus one clocks. In single-shot mode, a match also returns the counter to zero, and the hardware clears the run bit, so the timer stops. If software clears the run bit, the count freezes where it is.

Software can load the counter and the compare value directly. A write that lands in the same cycle as a hardware update takes effect in its place.

Top module: `cmp_timer`

## Requirements
- R1: After reset, control reads 0x0000_0000, status reads 0x0000_0000, counter reads 0x0000_0000, compare reads 0xFFFF_FFFF, and `irq` is 0.
- R2: The control register sits at offset 0x000 and has three fields. Bit 2 is the run bit, bit 1 selects single-shot mode (1) or periodic mode (0), and bit 0 enables the match interrupt. Bits 31:3 read as 0 whatever was written to them.
- R3: While the run bit is 1 and there is no match, the counter (offset 0x008) increases by one each clock. While the run bit is 0, the counter keeps its value.
- R4: In periodic mode, a clock with the run bit at 1 and counter equal to compare is a match. The counter is 0 after that clock, and counting continues.
- R5: In single-shot mode, a match clears the run bit and sets the counter to 0. A control write in the same cycle takes precedence for the control bits.
- R6: Status bit 0 (offset 0x004) is set by every match. Writing 1 to it clears it, and writing 0 has no effect. If a match and a clearing write fall in the same cycle, the flag ends up set.
- R7: `irq` equals status bit 0 AND the interrupt enable bit.
- R8: A write to the counter register loads the written value. This load takes precedence over an increment or a match reset in the same cycle.
- R9: Reads of any offset other than 0x000, 0x004, 0x008 and 0x00C return 0. Writes to such offsets change no register.
- R10: The compare register (offset 0x00C) holds the full 32-bit value written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq | output | 1 | Match interrupt |

## Verification
The bench targets the cycle in which a counter load coincides with a match. A design that gives the match priority would read back 0 where 0x55 is expected.

In single-shot mode, the bench checks that both the run bit and the count drop at the match. A design that only froze the counter would leave a nonzero count or a set run bit.

Status clears are written continuously while matches occur every few clocks. This catches a design in which the clear beats the set.

Undefined offsets, and writes to the reserved control bits, are checked at the read port. A decoder that aliases addresses would show corrupted control or compare values.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 12;

  localparam logic [ADDR_W-1:0] OFS_CTRL = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_STAT = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_CNT  = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_CMP  = 12'h00C;

  localparam int unsigned BIT_RUN  = 2;
  localparam int unsigned BIT_ONCE = 1;
  localparam int unsigned BIT_IEN  = 0;
  localparam int unsigned BIT_FLAG = 0;

  localparam logic [DATA_W-1:0] CMP_RST = '1;

  typedef struct packed {
    logic run;
    logic once;
    logic ien;
  } ctrl_t;
endpackage

// File: rtl/cmt_counter.sv
module cmt_counter
  import cmt_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic [W-1:0] cmp,
  output logic [W-1:0] cnt,
  output logic         match
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_ce;

  always_comb begin
    match  = run && (cnt_q == cmp);
    cnt_ce = ld | run;
    if (ld)         cnt_d = ld_val;
    else if (match) cnt_d = '0;
    else            cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  assert_hold_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !ld) |=> $stable(cnt));
  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !ld && (cnt != cmp)) |=> (cnt == $past(cnt) + W'(1)));
  assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !ld && (cnt == cmp)) |=> (cnt == '0));
  assert_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (cnt == $past(ld_val)));
endmodule

// File: rtl/cmt_regs.sv
module cmt_regs
  import cmt_pkg::*;
#(
  parameter int unsigned W  = DATA_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic [W-1:0]  cnt,
  input  logic          match,
  output ctrl_t         ctrl,
  output logic          flag,
  output logic [W-1:0]  cmp,
  output logic          cnt_ld
);
  ctrl_t        ctrl_q, ctrl_d;
  logic         flag_q, flag_d;
  logic [W-1:0] cmp_q;
  logic         wr_ctrl, wr_stat, wr_cmp, wr_any;
  logic         ctrl_ce, flag_ce;

  always_comb begin
    wr_any  = bus_sel && bus_wr;
    wr_ctrl = wr_any && (bus_addr == AW'(OFS_CTRL));
    wr_stat = wr_any && (bus_addr == AW'(OFS_STAT));
    cnt_ld  = wr_any && (bus_addr == AW'(OFS_CNT));
    wr_cmp  = wr_any && (bus_addr == AW'(OFS_CMP));
  end

  always_comb begin
    ctrl_d  = ctrl_q;
    ctrl_ce = 1'b0;
    if (wr_ctrl) begin
      ctrl_d.run  = bus_wdata[BIT_RUN];
      ctrl_d.once = bus_wdata[BIT_ONCE];
      ctrl_d.ien  = bus_wdata[BIT_IEN];
      ctrl_ce     = 1'b1;
    end else if (match && ctrl_q.once) begin
      ctrl_d.run = 1'b0;
      ctrl_ce    = 1'b1;
    end
  end

  always_comb begin
    flag_d  = flag_q;
    flag_ce = 1'b0;
    if (match) begin
      flag_d  = 1'b1;
      flag_ce = 1'b1;
    end else if (wr_stat && bus_wdata[BIT_FLAG]) begin
      flag_d  = 1'b0;
      flag_ce = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      flag_q <= 1'b0;
      cmp_q  <= CMP_RST;
    end else begin
      if (ctrl_ce) ctrl_q <= ctrl_d;
      if (flag_ce) flag_q <= flag_d;
      if (wr_cmp)  cmp_q  <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      AW'(OFS_CTRL): begin
        bus_rdata[BIT_RUN]  = ctrl_q.run;
        bus_rdata[BIT_ONCE] = ctrl_q.once;
        bus_rdata[BIT_IEN]  = ctrl_q.ien;
      end
      AW'(OFS_STAT): bus_rdata[BIT_FLAG] = flag_q;
      AW'(OFS_CNT):  bus_rdata = cnt;
      AW'(OFS_CMP):  bus_rdata = cmp_q;
      default:       bus_rdata = '0;
    endcase
  end

  assign ctrl = ctrl_q;
  assign flag = flag_q;
  assign cmp  = cmp_q;

  assert_once_stops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (match && ctrl.once && !wr_ctrl) |=> !ctrl.run);
  assert_flag_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> flag);
  assert_flag_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && bus_wdata[BIT_FLAG] && !match) |=> !flag);
  assert_stray_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_any && !wr_ctrl && !wr_stat && !cnt_ld && !wr_cmp && !match) |=>
      ($stable(ctrl) && $stable(cmp) && $stable(flag)));
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import cmt_pkg::*;
#(
  parameter int unsigned W  = DATA_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  output logic          irq
);
  ctrl_t        ctrl;
  logic         flag;
  logic [W-1:0] cmp;
  logic [W-1:0] cnt;
  logic         match;
  logic         cnt_ld;

  cmt_regs #(.W(W), .AW(AW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cnt       (cnt),
    .match     (match),
    .ctrl      (ctrl),
    .flag      (flag),
    .cmp       (cmp),
    .cnt_ld    (cnt_ld)
  );

  cmt_counter #(.W(W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (ctrl.run),
    .ld     (cnt_ld),
    .ld_val (bus_wdata),
    .cmp    (cmp),
    .cnt    (cnt),
    .match  (match)
  );

  assign irq = flag & ctrl.ien;

  assert_irq_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ctrl.ien);
endmodule

// File: tb/sim_cmp_timer.sv
`timescale 1ns/1ps
module sim_cmp_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cmp_timer u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // behavioural reference model
  bit          m_run, m_once, m_ien, m_flag;
  logic [31:0] m_cnt, m_cmp;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_once = 0; m_ien = 0; m_flag = 0;
      m_cnt = 0; m_cmp = 32'hFFFF_FFFF;
    end else begin
      bit hit, w;
      bit n_run;
      bit n_flag;
      logic [31:0] n_cnt;
      hit = m_run && (m_cnt == m_cmp);
      w = bus_sel && bus_wr;
      n_run = m_run;
      n_flag = m_flag;
      n_cnt = m_cnt;
      if (m_run) n_cnt = hit ? 32'd0 : m_cnt + 1;
      if (hit && m_once) n_run = 0;
      if (hit) n_flag = 1;
      else if (w && bus_addr == 12'h004 && bus_wdata[0]) n_flag = 0;
      if (w && bus_addr == 12'h000) begin
        n_run = bus_wdata[2]; m_once = bus_wdata[1]; m_ien = bus_wdata[0];
      end
      if (w && bus_addr == 12'h008) n_cnt = bus_wdata;
      if (w && bus_addr == 12'h00C) m_cmp = bus_wdata;
      m_run = n_run; m_flag = n_flag; m_cnt = n_cnt;
    end
  end

  function automatic logic [31:0] m_read(logic [11:0] a);
    case (a)
      12'h000: return {29'd0, m_run, m_once, m_ien};
      12'h004: return {31'd0, m_flag};
      12'h008: return m_cnt;
      12'h00C: return m_cmp;
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R7 irq", {31'd0, irq}, {31'd0, m_flag & m_ien});
      check("R2 R3 R4 R5 R6 R8 R9 R10 read", bus_rdata, m_read(bus_addr));
    end
  end

  task automatic wr(logic [11:0] a, logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(logic [11:0] a, logic [31:0] exp, string tag, output logic [31:0] act);
    bus_addr = a;
    @(negedge clk);
    act = bus_rdata;
    check(tag, act, exp);
    @(posedge clk); #1;
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v2;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;

    // R1 reset values
    rd(12'h000, 32'h0, "R1 ctrl", v);
    rd(12'h004, 32'h0, "R1 status", v);
    rd(12'h008, 32'h0, "R1 counter", v);
    rd(12'h00C, 32'hFFFF_FFFF, "R1 compare", v);
    check("R1 irq", {31'd0, irq}, 32'd0);

    // R10 compare readback, R2 reserved bits
    wr(12'h00C, 32'hA5C3_0F17);
    rd(12'h00C, 32'hA5C3_0F17, "R10 compare", v);
    wr(12'h000, 32'hFFFF_FFF8);
    rd(12'h000, 32'h0, "R2 reserved", v);

    // R9 undefined offsets
    wr(12'h010, 32'hFFFF_FFFF);
    wr(12'h002, 32'hFFFF_FFFF);
    rd(12'h010, 32'h0, "R9 undefined read", v);
    rd(12'h000, 32'h0, "R9 ctrl untouched", v);
    rd(12'h00C, 32'hA5C3_0F17, "R9 compare untouched", v);

    // R4 periodic with interrupt, R6 clear collisions
    wr(12'h00C, 32'd2);
    wr(12'h000, 32'h5);
    repeat (12) wr(12'h004, 32'h1);
    repeat (10) @(posedge clk);
    #1;
    rd(12'h004, 32'h1, "R6 flag after matches", v);
    check("R7 irq on", {31'd0, irq}, 32'd1);

    // R3 software stop freezes count
    wr(12'h000, 32'h0);
    rd(12'h008, m_cnt, "R3 frozen", v);
    repeat (5) @(posedge clk);
    #1;
    rd(12'h008, v, "R3 still frozen", v2);

    // R6 write-0 no effect, write-1 clears
    wr(12'h004, 32'h0);
    rd(12'h004, 32'h1, "R6 write zero", v);
    wr(12'h004, 32'h1);
    rd(12'h004, 32'h0, "R6 write one", v);

    // R5 single shot
    wr(12'h008, 32'd0);
    wr(12'h00C, 32'd3);
    wr(12'h000, 32'h6);
    repeat (10) @(posedge clk);
    #1;
    rd(12'h000, 32'h2, "R5 run cleared", v);
    rd(12'h008, 32'h0, "R5 count zero", v);
    rd(12'h004, 32'h1, "R6 single shot flag", v);
    check("R7 irq masked", {31'd0, irq}, 32'd0);
    wr(12'h000, 32'h3);
    check("R7 irq unmasked", {31'd0, irq}, 32'd1);

    // R8 load beats match in the same cycle
    wr(12'h004, 32'h1);
    wr(12'h008, 32'd7);
    wr(12'h00C, 32'd7);
    wr(12'h000, 32'h4);
    wr(12'h008, 32'h55);
    rd(12'h008, 32'h55, "R8 load over match", v);
    rd(12'h004, 32'h1, "R6 flag on load match", v);
    rd(12'h008, 32'h57, "R3 counting after load", v);

    // R8 plain load while running, then free-run
    wr(12'h008, 32'h1000);
    rd(12'h008, 32'h1000, "R8 load", v);
    repeat (30) @(posedge clk);
    #1;

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule